// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block is a read-only instruction cache that sits between an instruction fetch unit and a plain word-wide memory port. It holds 128 sets of 8 ways, and each line is 32 bytes (eight 32-bit words). A fetch is accepted when `req_ready` is high. The address is split into a tag, a set index and a word index. If a valid way in the addressed set holds a matching tag, the word is returned on the next cycle. Otherwise the controller reads the whole aligned line from memory, one word per handshake. It stores the line in a victim way, records the tag, and only then returns the requested word.

A victim way is picked as follows. The lowest-numbered empty way is used if one exists. Otherwise a seven-node binary tree per set points away from recently used ways and selects the victim. When `cache_en` is low, fetches read one word directly from memory and leave the cache state alone. The invalidate port clears every way of one set. If a line fill to that same set is in progress, the clear is held back and applied when the fill completes.

Top module: `icache_ctrl`

## Requirements
- R1: The address fields are: tag = bits 31:12, set index = bits 11:5, word within the line = bits 4:2. Bits 1:0 are ignored. A hit needs a valid way in the addressed set whose stored tag equals the request tag.
- R2: A hit that is accepted at a clock edge raises `resp_valid` for one cycle just after that edge. `resp_data` then carries the stored word, and no memory read takes place.
- R3: A miss issues exactly eight reads. They are at the line base (address with bits 4:0 cleared) and then every following word in ascending order. `mem_addr` stays stable while `mem_ready` is low. The response comes after the eighth word is taken and carries the word at the requested address with bits 1:0 cleared.
- R4: While a set still has an empty way, a miss fills the lowest-numbered empty way, so no valid line is evicted.
- R5: In a full set the victim comes from a 7-bit tree (node n has children 2n+1 and 2n+2). Starting at node 0, a node bit of 1 steps to the right child, and the three steps give the way number from the most significant bit down. Every hit or fill to a way sets each node on that way's path to point away from it.
- R6: With `cache_en` low, a fetch makes exactly one memory read at the request address with bits 1:0 cleared and returns that word. It leaves the cache contents and the replacement state unchanged.
- R7: An invalidate with `cache_en` high clears all eight ways of the set given by `inv_addr` bits 11:5, whatever their tags. With `cache_en` low it is ignored.
- R8: An invalidate that targets the set being filled is applied when the fill completes, so the new line is invalid afterwards. An invalidate that targets another set during a fill takes effect at once.
- R9: When an invalidate and a hit to the same set fall on the same edge, the hit is served from the old contents and the set is invalid afterwards.
- R10: After reset all lines are invalid, the trees are zero, `req_ready` is high, and `resp_valid` and `mem_valid` are low.
- R11: Only one fetch is handled at a time: `req_ready` is low from the edge that accepts a miss or a bypass fetch until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; low means direct memory reads and no invalidates |
| req_valid | input | 1 | Fetch request valid |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Controller can accept a fetch this cycle |
| resp_valid | output | 1 | One-cycle pulse with the fetched word |
| resp_data | output | 32 | Fetched instruction word |
| inv_valid | input | 1 | Invalidate-set request |
| inv_addr | input | 32 | Address whose set is invalidated |
| mem_valid | output | 1 | Memory read request valid |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ready | input | 1 | Memory accepts the read and presents data this cycle |
| mem_rdata | input | 32 | Memory read data, valid with the handshake |

## Verification
Invalidate can coincide with two other functions in the same cycle. The first is a hit lookup to the same set. The bench provokes this by driving the invalidate and the fetch on the same edge. It expects the old word with zero memory reads, and then expects a refetch of that address to miss. The second is a line fill in progress. The bench starts a miss in one thread and pulses an invalidate a few cycles later from a second thread. It does this once for the filling set, which must end invalid, so a refetch issues eight reads. It does this once for another resident set, whose line must be gone at once. A reference model of tags, valid bits and trees predicts the hit or miss outcome and the read count of every fetch in a long pseudo-random sweep.

// File: rtl/icache_pkg.sv
// Shared types for the instruction cache controller.
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_BYPASS = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/icache_tags.sv
// Tag and valid storage with parallel compare.
// Does: holds one tag and one valid bit per way. It compares all ways of
// the looked-up set, records a tag when a fill finishes, and clears whole
// sets. Assumes: SETS and WAYS are powers of two. A kill clears the row
// written in the same cycle, after the write.
module icache_tags #(
    parameter int SETS  = 128,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic [WAYS-1:0]  lk_valid,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_kill,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set
);
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS*WAYS];
    logic [WAYS-1:0]  match;

    assign lk_valid = valid_q[lk_set];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_q[lk_set][w] && (tag_q[{lk_set, WAY_W'(w)}] == lk_tag);
        end
    endgenerate

    // Encode the matching way.
    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
        lk_hit = |match;
    end

    // Valid bits: fill sets a bit (or clears the row on kill), invalidate clears a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            if (wr_en)
                valid_q[wr_set] <= wr_kill ? '0 : (valid_q[wr_set] | (WAYS'(1) << wr_way));
            if (inv_en)
                valid_q[inv_set] <= '0;
        end
    end

    // Tag record on fill completion.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[{wr_set, wr_way}] <= wr_tag;
    end

    // Remember the last invalidate for the check below.
    logic             inv_d;
    logic [SET_W-1:0] inv_set_d;
    always_ff @(posedge clk) begin
        if (!rst_n) inv_d <= 1'b0;
        else        inv_d <= inv_en;
        inv_set_d <= inv_set;
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_d |-> (valid_q[inv_set_d] == '0));
endmodule

// File: rtl/icache_plru.sv
// Replacement selector: first empty way, else tree pseudo-LRU.
// Does: keeps a WAYS-1 bit tree per set and names a victim for the
// looked-up set. It re-points the tree away from each accessed way.
// Assumes: WAYS is a power of two, at least 2.
module icache_plru #(
    parameter int SETS = 128,
    parameter int WAYS = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] sel_set,
    input  logic [WAYS-1:0]  sel_valid,
    output logic [WAY_W-1:0] victim,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);
    logic [WAYS-2:0]  tree_q [SETS];
    logic [WAYS-2:0]  cur_tree, next_tree;
    logic [WAY_W-1:0] walk_n, upd_n;
    logic             found;

    assign cur_tree = tree_q[sel_set];

    // Victim choice: lowest empty way, otherwise walk the tree.
    always_comb begin
        victim = '0;
        found  = 1'b0;
        walk_n = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !sel_valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int l = 0; l < WAY_W; l++) begin
                victim[WAY_W-1-l] = cur_tree[walk_n];
                walk_n = (walk_n << 1) + WAY_W'(1) + WAY_W'(cur_tree[walk_n]);
            end
        end
    end

    // Tree update: point every node on the accessed path away from it.
    always_comb begin
        next_tree = tree_q[touch_set];
        upd_n     = '0;
        for (int l = 0; l < WAY_W; l++) begin
            next_tree[upd_n] = ~touch_way[WAY_W-1-l];
            upd_n = (upd_n << 1) + WAY_W'(1) + WAY_W'(touch_way[WAY_W-1-l]);
        end
    end

    // Tree storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= next_tree;
        end
    end

    // Last access, kept for the check below.
    logic             touch_d;
    logic [SET_W-1:0] touch_set_d;
    logic [WAY_W-1:0] touch_way_d;
    always_ff @(posedge clk) begin
        if (!rst_n) touch_d <= 1'b0;
        else        touch_d <= touch_en;
        touch_set_d <= touch_set;
        touch_way_d <= touch_way;
    end

    assert_victim_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid != '1) |-> !sel_valid[victim]);

    assert_mru_not_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_d && sel_set == touch_set_d && sel_valid == '1) |-> (victim != touch_way_d));
endmodule

// File: rtl/icache_ctrl.sv
// Instruction cache controller top.
// Does: accepts one fetch at a time. It serves hits in one cycle, fills
// misses with sequential word reads, bypasses when disabled, and applies
// set invalidates (deferring those that hit the set being filled).
// Assumes: the memory returns data in the same cycle as mem_ready. Line
// size and way count are powers of two.
module icache_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 8,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    import icache_pkg::*;

    localparam int OFF_W  = $clog2(LINE_WORDS * WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int BSEL_W = OFF_W - WSEL_W;
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LINE_W = LINE_WORDS * WORD_W;

    fetch_state_e              state_q;
    logic [ADDR_W-1:BSEL_W]    addr_q;
    logic [WAY_W-1:0]          way_q;
    logic [WSEL_W-1:0]         beat_q;
    logic                      pend_q;
    logic [WORD_W-1:0]         word_q;
    logic [LINE_W-1:0]         line_q [SETS*WAYS];

    logic [SET_W-1:0]  rq_set, fl_set, iv_set;
    logic [TAG_W-1:0]  rq_tag, fl_tag;
    logic [WSEL_W-1:0] rq_word, fl_word;
    logic              accept, mem_fire, fill_last, inv_fire, inv_same, inv_now, kill;
    logic              hit;
    logic [WAY_W-1:0]  hit_way, victim;
    logic [WAYS-1:0]   set_valid;
    logic [WORD_W-1:0] hit_word;

    assign rq_set  = req_addr[OFF_W +: SET_W];
    assign rq_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign rq_word = req_addr[BSEL_W +: WSEL_W];
    assign fl_set  = addr_q[OFF_W +: SET_W];
    assign fl_tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign fl_word = addr_q[BSEL_W +: WSEL_W];
    assign iv_set  = inv_addr[OFF_W +: SET_W];

    logic unused_bits;
    assign unused_bits = ^{req_addr[BSEL_W-1:0], inv_addr[ADDR_W-1:OFF_W+SET_W], inv_addr[OFF_W-1:0]};

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_valid = (state_q != ST_IDLE);
    assign mem_fire  = mem_valid && mem_ready;
    assign fill_last = (state_q == ST_FILL) && mem_fire && (beat_q == '1);
    assign inv_fire  = inv_valid && cache_en;
    assign inv_same  = (state_q == ST_FILL) && (iv_set == fl_set);
    assign inv_now   = inv_fire && !inv_same;
    assign kill      = fill_last && (pend_q || (inv_fire && inv_same));
    assign hit_word  = line_q[{rq_set, hit_way}][rq_word*WORD_W +: WORD_W];

    // Memory address: line walk during a fill, single word in bypass.
    always_comb begin
        if (state_q == ST_FILL) mem_addr = {addr_q[ADDR_W-1:OFF_W], beat_q, {BSEL_W{1'b0}}};
        else                    mem_addr = {addr_q, {BSEL_W{1'b0}}};
    end

    icache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(rq_set), .lk_tag(rq_tag),
        .lk_hit(hit), .lk_way(hit_way), .lk_valid(set_valid),
        .wr_en(fill_last), .wr_set(fl_set), .wr_way(way_q), .wr_tag(fl_tag), .wr_kill(kill),
        .inv_en(inv_now), .inv_set(iv_set)
    );

    icache_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .sel_set(rq_set), .sel_valid(set_valid), .victim(victim),
        .touch_en(accept && cache_en), .touch_set(rq_set),
        .touch_way(hit ? hit_way : victim)
    );

    // Control: state, beat count, response strobe, deferred invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            resp_valid <= 1'b0;
            beat_q     <= '0;
            pend_q     <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            if (fill_last)                  pend_q <= 1'b0;
            else if (inv_fire && inv_same)  pend_q <= 1'b1;
            case (state_q)
                ST_IDLE: if (accept) begin
                    beat_q <= '0;
                    if (!cache_en)  state_q    <= ST_BYPASS;
                    else if (hit)   resp_valid <= 1'b1;
                    else            state_q    <= ST_FILL;
                end
                ST_FILL: if (mem_fire) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == '1) begin
                        state_q    <= ST_IDLE;
                        resp_valid <= 1'b1;
                    end
                end
                ST_BYPASS: if (mem_fire) begin
                    state_q    <= ST_IDLE;
                    resp_valid <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath: request capture, line writes and response word.
    always_ff @(posedge clk) begin
        if (accept) addr_q <= req_addr[ADDR_W-1:BSEL_W];
        if (accept && cache_en && !hit) way_q <= victim;
        if (accept && cache_en && hit) resp_data <= hit_word;
        if (state_q == ST_FILL && mem_fire) begin
            line_q[{fl_set, way_q}][beat_q*WORD_W +: WORD_W] <= mem_rdata;
            if (beat_q == fl_word) word_q <= mem_rdata;
            if (beat_q == '1) resp_data <= (fl_word == '1) ? mem_rdata : word_q;
        end
        if (state_q == ST_BYPASS && mem_fire) resp_data <= mem_rdata;
    end

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cache_en && hit) |=> (resp_valid && !mem_valid));

    assert_fill_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_fire && beat_q != '1) |=> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_W/8)));

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    assert_bypass_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS && mem_fire) |=> (req_ready && resp_valid));

    assert_busy_after_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(cache_en && hit)) |=> !req_ready);
endmodule

// File: tb/sim_icache_ctrl.sv
`timescale 1ns/1ps
module sim_icache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_data;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_addr = '0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    icache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        mem_ready = (cyc % 4) != 1;
    end

    int          beat_cnt = 0;
    logic [31:0] beat_addr [16];
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (beat_cnt < 16) beat_addr[beat_cnt] = mem_addr;
            beat_cnt++;
        end
    end

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model: valid bits, tags and trees per set.
    bit [7:0]  mv [128];
    bit [19:0] mt [128][8];
    bit [6:0]  mp [128];

    function automatic int m_lookup(int s, bit [19:0] t);
        for (int w = 0; w < 8; w++) if (mv[s][w] && mt[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int m_victim(int s);
        int n = 0, w = 0;
        for (int i = 0; i < 8; i++) if (!mv[s][i]) return i;
        for (int l = 0; l < 3; l++) begin
            int b = int'(mp[s][n]);
            w = w * 2 + b;
            n = 2 * n + 1 + b;
        end
        return w;
    endfunction

    task automatic m_touch(int s, int w);
        int n = 0;
        for (int l = 0; l < 3; l++) begin
            int d = (w >> (2 - l)) & 1;
            mp[s][n] = (d == 0);
            n = 2 * n + 1 + d;
        end
    endtask

    task automatic fetch(input logic [31:0] a, input bit with_inv, input string req);
        int s, w, lat, exp_beats;
        bit ok;
        bit [19:0] t;
        s = int'(a[11:5]);
        t = a[31:12];
        @(negedge clk);
        beat_cnt = 0;
        req_valid = 1'b1;
        req_addr = a;
        if (with_inv) begin inv_valid = 1'b1; inv_addr = a; end
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (with_inv) inv_valid = 1'b0;
        lat = 0;
        @(negedge clk);
        while (!resp_valid && lat < 200) begin lat++; @(negedge clk); end
        check(resp_valid, req, "response seen", 32'(resp_valid), 32'd1);
        check(resp_data == mem_fn({a[31:2], 2'b00}), req, "word", resp_data, mem_fn({a[31:2], 2'b00}));
        if (!cache_en) begin
            exp_beats = 1;
            check(beat_addr[0] == {a[31:2], 2'b00}, req, "bypass address", beat_addr[0], {a[31:2], 2'b00});
        end else begin
            w = m_lookup(s, t);
            if (w >= 0) begin
                exp_beats = 0;
                check(lat == 0, req, "hit latency", 32'(lat), 32'd0);
            end else begin
                exp_beats = 8;
                w = m_victim(s);
                mv[s][w] = 1'b1;
                mt[s][w] = t;
                ok = 1'b1;
                for (int i = 0; i < 8; i++)
                    if (beat_addr[i] != {a[31:5], 5'b0} + 32'(4 * i)) ok = 1'b0;
                check(ok, req, "fill address order", beat_addr[0], {a[31:5], 5'b0});
            end
            m_touch(s, w);
            if (with_inv) mv[s] = '0;
        end
        check(beat_cnt == exp_beats, req, "memory reads", 32'(beat_cnt), 32'(exp_beats));
    endtask

    task automatic pulse_inv(input logic [31:0] a);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_addr = a;
        @(posedge clk);
        #1;
        inv_valid = 1'b0;
    endtask

    task automatic invalidate(input logic [31:0] a);
        pulse_inv(a);
        if (cache_en) mv[a[11:5]] = '0;
    endtask

    function automatic logic [31:0] mk(int tag, int set, int word, int bytesel);
        return {20'(tag), 7'(set), 3'(word), 2'(bytesel)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle outputs after reset
        check(req_ready == 1'b1, "R10", "req_ready", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R10", "resp_valid", 32'(resp_valid), 32'd0);
        check(mem_valid == 1'b0, "R10", "mem_valid", 32'(mem_valid), 32'd0);

        // R4: eight tags fill set 5 without eviction, then all hit
        for (int k = 0; k < 8; k++) fetch(mk(k + 1, 5, k, 0), 1'b0, "R4");
        for (int k = 0; k < 8; k++) fetch(mk(k + 1, 5, 7 - k, 2), 1'b0, "R4");

        // R5: touch some ways, evict with new tags, probe the old ones
        fetch(mk(3, 5, 0, 0), 1'b0, "R5");
        fetch(mk(1, 5, 1, 0), 1'b0, "R5");
        fetch(mk(7, 5, 2, 0), 1'b0, "R5");
        fetch(mk(9, 5, 3, 0), 1'b0, "R5");
        fetch(mk(10, 5, 4, 0), 1'b0, "R5");
        for (int k = 1; k <= 10; k++) fetch(mk(k, 5, k % 8, 0), 1'b0, "R5");

        // R6 and R7: bypass and ignored invalidate while disabled
        cache_en = 1'b0;
        fetch(mk(3, 5, 6, 3), 1'b0, "R6");
        invalidate(mk(0, 5, 0, 0));
        cache_en = 1'b1;
        fetch(mk(3, 5, 6, 0), 1'b0, "R6");
        fetch(mk(9, 5, 1, 0), 1'b0, "R7");

        // R7: enabled invalidate clears every way of the set
        invalidate(mk(55, 5, 0, 0));
        fetch(mk(3, 5, 2, 0), 1'b0, "R7");
        fetch(mk(9, 5, 2, 0), 1'b0, "R7");

        // R8: invalidate to the filling set is applied after the fill
        fork
            fetch(mk(20, 9, 4, 0), 1'b0, "R8");
            begin repeat (3) @(negedge clk); pulse_inv(mk(0, 9, 0, 0)); end
        join
        mv[9] = '0;
        fetch(mk(20, 9, 4, 0), 1'b0, "R8");

        // R8: invalidate to another set during a fill is applied at once
        fetch(mk(30, 10, 0, 0), 1'b0, "R8");
        fork
            fetch(mk(31, 11, 5, 0), 1'b0, "R8");
            begin repeat (3) @(negedge clk); pulse_inv(mk(0, 10, 0, 0)); end
        join
        mv[10] = '0;
        fetch(mk(30, 10, 0, 0), 1'b0, "R8");
        fetch(mk(31, 11, 5, 0), 1'b0, "R8");

        // R9: invalidate and hit on the same edge
        fetch(mk(40, 12, 3, 0), 1'b0, "R9");
        fetch(mk(40, 12, 3, 0), 1'b1, "R9");
        fetch(mk(40, 12, 3, 0), 1'b0, "R9");

        // R1 and R3: pseudo-random sweep over a few sets and twelve tags
        r = 12345;
        for (int i = 0; i < 600; i++) begin
            int sets_pick [4] = '{0, 1, 64, 127};
            r = r * 1103515245 + 12345;
            if (i % 29 == 28)
                invalidate(mk(0, sets_pick[(r >>> 20) & 3], 0, 0));
            else
                fetch(mk((((r >>> 8) & 32'hFF) % 12) * 32'h1F3B7, sets_pick[(r >>> 20) & 3],
                         (r >>> 16) & 7, (r >>> 24) & 3), 1'b0, "R1");
        end
        // R11: controller returns to ready
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "ready after last fetch", 32'(req_ready), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule